// File: doc/BRIEF.md
# Masked Lane AND-NOT Unit

This block is one vector execution slice of a 512-bit datapath. It splits its operands into 32-bit lanes and, in each lane, inverts the first source and ANDs it with the second source. The lane result is then merged into the old destination value according to a per-lane write mask, a vector-length code and an encoding-mode flag. The operation is purely bitwise: floating-point values pass through as raw bit patterns.

An issue stage presents both sources, the old destination, the mask controls and the mode controls together with `in_valid`. One clock later the full 512-bit destination appears on `result` with `out_valid`. Two encoding families are supported:

- **Non-legacy mode.** Lanes above the active vector length are cleared.
- **Legacy 128-bit mode.** The old destination is also the first source, and the upper bits of the destination are kept.

Top module: `lane_andn_unit`

## Requirements
- R1: For every written lane j (bits 32*j+31 down to 32*j), the lane result equals the bitwise complement of the first-source lane ANDed with the second-source lane. The second source is never inverted. A lane is written when `mask_on` is 0 or `lane_mask[j]` is 1.
- R2: Outside legacy mode, `vlen_code` selects the active width:
  - 0 selects 4 lanes (128 bits).
  - 1 selects 8 lanes (256 bits).
  - 2 selects 16 lanes (512 bits).
- R3: With `mask_on`=1 and `zero_mode`=0, an active lane whose mask bit is 0 takes the old destination lane.
- R4: With `mask_on`=1 and `zero_mode`=1, an active lane whose mask bit is 0 becomes all zeros.
- R5: When `bcast`=1 and `b_is_mem`=1 outside legacy mode, every lane uses `src_b[31:0]` as its second operand. When `bcast`=1 and `b_is_mem`=0, the broadcast has no effect.
- R6: Outside legacy mode, every result bit from the active width up to bit 511 is 0.
- R7: With `legacy`=1, the following hold:
  - Lanes 0 to 3 compute NOT(`old_dst` lane) AND `src_b` lane.
  - Bits 511:128 equal `old_dst[511:128]`.
  - `src_a` and `vlen_code` have no effect.
  - `vlen_err` is 0.
- R8: With `legacy`=1, the inputs `mask_on`, `lane_mask`, `zero_mode`, `bcast` and `b_is_mem` have no effect on the result.
- R9: `out_valid` equals `in_valid` of the previous cycle. `result` and `vlen_err` load only when `in_valid` was 1, and otherwise hold their values.
- R10: Outside legacy mode, `vlen_code`=3 is processed as 16 lanes (512 bits) and sets `vlen_err` to 1 with that result. Any other code gives `vlen_err`=0.
- R11: A synchronous active-high `rst` clears `out_valid`, `result` and `vlen_err` to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| src_a | input | 512 | First source (complemented) |
| src_b | input | 512 | Second source |
| old_dst | input | 512 | Previous destination value |
| lane_mask | input | 16 | Per-lane write mask |
| mask_on | input | 1 | Masking in use |
| zero_mode | input | 1 | 1 = zero masked lanes, 0 = merge |
| bcast | input | 1 | Broadcast request for source 2 |
| b_is_mem | input | 1 | Source 2 comes from memory |
| vlen_code | input | 2 | Vector-length code (0/1/2, 3 unsupported) |
| legacy | input | 1 | Legacy 128-bit mode |
| out_valid | output | 1 | Result valid |
| result | output | 512 | Registered destination value |
| vlen_err | output | 1 | Unsupported length code flagged |

## Verification
The embedded properties assume that the control inputs are stable, known values whenever `in_valid` is high. They also assume that `old_dst` sampled with a transaction is the value the upper-bit checks compare against.

The stimulus meets these assumptions in two ways:
- Every input is changed only on the falling clock edge.
- Every transaction is held for exactly one rising edge.

A near-exhaustive sweep drives every combination of legacy flag, length code, mask enable, zeroing, broadcast and memory flag. Each combination is run under several mask patterns and pseudo-random data, so that no mode combination falls outside the assumed envelope.

// File: rtl/landn_pkg.sv
package landn_pkg;

  // Vector-length codes as seen on the vlen_code port
  typedef enum logic [1:0] {
    VLEN_128  = 2'd0,
    VLEN_256  = 2'd1,
    VLEN_512  = 2'd2,
    VLEN_RSVD = 2'd3
  } vlen_e;

  // Width covered by the legacy encoding
  localparam int unsigned LEGACY_BITS = 128;

  // Active width in bits for a length code; reserved code runs as full width
  function automatic int unsigned vlen_bits(input vlen_e code);
    case (code)
      VLEN_128: return 128;
      VLEN_256: return 256;
      default:  return 512;
    endcase
  endfunction

  function automatic logic vlen_reserved(input vlen_e code);
    return code == VLEN_RSVD;
  endfunction

endpackage

// File: rtl/landn_len_decode.sv
module landn_len_decode
  import landn_pkg::*;
#(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned LANES  = 16
) (
  input  logic [1:0]       vlen_code,
  input  logic             legacy,
  output logic [LANES-1:0] lane_active,
  output logic [LANES-1:0] lane_keep,
  output logic             len_bad
);

  logic [31:0] span_bits;

  always_comb begin
    if (legacy) span_bits = 32'(LEGACY_BITS);
    else        span_bits = 32'(vlen_bits(vlen_e'(vlen_code)));
  end

  assign len_bad = ~legacy & vlen_reserved(vlen_e'(vlen_code));

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam logic [31:0] TOP_BIT = 32'((j + 1) * LANE_W);
    assign lane_active[j] = (TOP_BIT <= span_bits);
    // legacy keeps everything above its width untouched
    assign lane_keep[j]   = legacy & ~lane_active[j];
  end

endmodule

// File: rtl/landn_lane.sv
module landn_lane #(
  parameter int unsigned LANE_W = 32
) (
  input  logic [LANE_W-1:0] opnd_a,
  input  logic [LANE_W-1:0] opnd_b,
  input  logic [LANE_W-1:0] prev_val,
  input  logic              active,
  input  logic              keep,
  input  logic              write_en,
  input  logic              zero_mode,
  output logic [LANE_W-1:0] lane_out
);

  function automatic logic [LANE_W-1:0] andn(input logic [LANE_W-1:0] a,
                                             input logic [LANE_W-1:0] b);
    return (~a) & b;
  endfunction

  always_comb begin
    if (keep)           lane_out = prev_val;
    else if (!active)   lane_out = '0;
    else if (write_en)  lane_out = andn(opnd_a, opnd_b);
    else if (zero_mode) lane_out = '0;
    else                lane_out = prev_val;
  end

endmodule

// File: rtl/lane_andn_unit.sv
module lane_andn_unit
  import landn_pkg::*;
#(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned LANES  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [LANE_W*LANES-1:0] src_a,
  input  logic [LANE_W*LANES-1:0] src_b,
  input  logic [LANE_W*LANES-1:0] old_dst,
  input  logic [LANES-1:0]        lane_mask,
  input  logic                    mask_on,
  input  logic                    zero_mode,
  input  logic                    bcast,
  input  logic                    b_is_mem,
  input  logic [1:0]              vlen_code,
  input  logic                    legacy,
  output logic                    out_valid,
  output logic [LANE_W*LANES-1:0] result,
  output logic                    vlen_err
);

  localparam int unsigned VEC_W = LANE_W * LANES;

  // Named internal events
  logic             bcast_eff;
  logic             mask_eff;
  logic             zero_eff;
  logic [LANES-1:0] lane_active;
  logic [LANES-1:0] lane_keep;
  logic [LANES-1:0] lane_wr;
  logic             len_bad;
  logic [VEC_W-1:0] next_res;

  assign bcast_eff = bcast & b_is_mem & ~legacy;
  assign mask_eff  = mask_on & ~legacy;
  assign zero_eff  = zero_mode & ~legacy;

  landn_len_decode #(.LANE_W(LANE_W), .LANES(LANES)) len_i (
    .vlen_code   (vlen_code),
    .legacy      (legacy),
    .lane_active (lane_active),
    .lane_keep   (lane_keep),
    .len_bad     (len_bad)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] op_a;
    logic [LANE_W-1:0] op_b;

    assign op_a       = legacy    ? old_dst[j*LANE_W +: LANE_W] : src_a[j*LANE_W +: LANE_W];
    assign op_b       = bcast_eff ? src_b[LANE_W-1:0]           : src_b[j*LANE_W +: LANE_W];
    assign lane_wr[j] = ~mask_eff | lane_mask[j];

    landn_lane #(.LANE_W(LANE_W)) lane_i (
      .opnd_a    (op_a),
      .opnd_b    (op_b),
      .prev_val  (old_dst[j*LANE_W +: LANE_W]),
      .active    (lane_active[j]),
      .keep      (lane_keep[j]),
      .write_en  (lane_wr[j]),
      .zero_mode (zero_eff),
      .lane_out  (next_res[j*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      vlen_err  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= next_res;
        vlen_err <= len_bad;
      end
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && $stable(vlen_err));

  // R10
  bad_len_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legacy && vlen_code == 2'd3) |=> vlen_err);

  // R7
  legacy_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legacy) |=> !vlen_err);

  // R4
  zero_lane0_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legacy && mask_on && zero_mode && !lane_mask[0])
      |=> result[LANE_W-1:0] == '0);

  // R3
  merge_lane0_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legacy && mask_on && !zero_mode && !lane_mask[0])
      |=> result[LANE_W-1:0] == $past(old_dst[LANE_W-1:0]));

  if (VEC_W > LEGACY_BITS) begin : g_upper_chk
    // R7
    legacy_upper_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && legacy) |=> result[VEC_W-1:LEGACY_BITS] == $past(old_dst[VEC_W-1:LEGACY_BITS]));

    // R6
    short_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !legacy && vlen_code == 2'd0) |=> result[VEC_W-1:LEGACY_BITS] == '0);
  end

endmodule

// File: tb/lane_andn_unit_tb_top.sv
module lane_andn_unit_tb_top;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [511:0] src_a, src_b, old_dst;
  logic [15:0]  lane_mask;
  logic         mask_on, zero_mode, bcast, b_is_mem, legacy;
  logic [1:0]   vlen_code;
  logic         out_valid;
  logic [511:0] result;
  logic         vlen_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #5 clk = ~clk;

  lane_andn_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .old_dst(old_dst),
    .lane_mask(lane_mask), .mask_on(mask_on), .zero_mode(zero_mode),
    .bcast(bcast), .b_is_mem(b_is_mem), .vlen_code(vlen_code), .legacy(legacy),
    .out_valid(out_valid), .result(result), .vlen_err(vlen_err)
  );

  function automatic logic [511:0] model(
    input logic [511:0] a, input logic [511:0] b, input logic [511:0] d,
    input logic [15:0] m, input logic mon, input logic zm, input logic bc,
    input logic mem, input logic [1:0] vc, input logic leg);
    logic [511:0] e;
    int width;
    width = (vc == 2'd0) ? 128 : (vc == 2'd1) ? 256 : 512;
    for (int k = 0; k < 512; k++) begin
      logic bb;
      if (leg) begin
        e[k] = (k < 128) ? (!d[k] && b[k]) : d[k];
      end else if (k >= width) begin
        e[k] = 1'b0;
      end else begin
        bb = (bc && mem) ? b[k % 32] : b[k];
        if (!mon || m[k / 32]) e[k] = !a[k] && bb;
        else                   e[k] = zm ? 1'b0 : d[k];
      end
    end
    return e;
  endfunction

  task automatic rand512(output logic [511:0] v);
    for (int w = 0; w < 8; w++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      v[w*64 +: 64] = rng;
    end
  endtask

  task automatic check(input string tag, input logic [511:0] got, input logic [511:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // Drive at a falling edge; check at the next falling edge
  task automatic txn(input string tag,
    input logic [511:0] a, input logic [511:0] b, input logic [511:0] d,
    input logic [15:0] m, input logic mon, input logic zm, input logic bc,
    input logic mem, input logic [1:0] vc, input logic leg);
    src_a = a; src_b = b; old_dst = d; lane_mask = m; mask_on = mon;
    zero_mode = zm; bcast = bc; b_is_mem = mem; vlen_code = vc; legacy = leg;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, result, model(a, b, d, m, mon, zm, bc, mem, vc, leg));
    check("R9 valid", {511'd0, out_valid}, 512'd1);
    check("R10 err", {511'd0, vlen_err}, {511'd0, (!leg && vc == 2'd3)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [511:0] ra, rb, rd, held;
    logic [15:0] masks [4];
    masks[0] = 16'h0000; masks[1] = 16'hFFFF; masks[2] = 16'hA5C3; masks[3] = 16'h0001;
    rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0; old_dst = '0;
    lane_mask = '0; mask_on = 0; zero_mode = 0; bcast = 0; b_is_mem = 0;
    vlen_code = 2'd2; legacy = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 reset result", result, '0);
    check("R11 reset valid/err", {510'd0, out_valid, vlen_err}, '0);

    // R1 complement of source 1 only
    txn("R1 not-a", {16{32'h0F0F_00FF}}, {512{1'b1}}, '0, '0, 0, 0, 0, 0, 2'd2, 0);
    check("R1 value", result, {16{32'hF0F0_FF00}});
    txn("R1 b passes", '0, {16{32'h1234_5678}}, '0, '0, 0, 0, 0, 0, 2'd2, 0);
    check("R1 b not inverted", result, {16{32'h1234_5678}});

    // R3 merge, R4 zero
    txn("R3 merge", '0, {512{1'b1}}, {16{32'hDEAD_BEEF}}, 16'h00FF, 1, 0, 0, 0, 2'd2, 0);
    check("R3 value", result, {{8{32'hDEAD_BEEF}}, {8{32'hFFFF_FFFF}}});
    txn("R4 zero", '0, {512{1'b1}}, {16{32'hDEAD_BEEF}}, 16'h00FF, 1, 1, 0, 0, 2'd2, 0);
    check("R4 value", result, {{8{32'h0}}, {8{32'hFFFF_FFFF}}});

    // R5 broadcast
    rand512(rb);
    txn("R5 bcast mem", '0, rb, '0, '0, 0, 0, 1, 1, 2'd2, 0);
    check("R5 bcast value", result, {16{rb[31:0]}});
    txn("R5 bcast reg", '0, rb, '0, '0, 0, 0, 1, 0, 2'd2, 0);
    check("R5 no bcast value", result, rb);

    // R2 and R6 widths
    txn("R2 128", '0, {512{1'b1}}, {512{1'b1}}, '0, 0, 0, 0, 0, 2'd0, 0);
    check("R6 128 upper", result, {384'd0, {128{1'b1}}});
    txn("R2 256", '0, {512{1'b1}}, {512{1'b1}}, '0, 0, 0, 0, 0, 2'd1, 0);
    check("R6 256 upper", result, {256'd0, {256{1'b1}}});

    // R10 reserved code
    txn("R10 rsvd", '0, {512{1'b1}}, '0, '0, 0, 0, 0, 0, 2'd3, 0);
    check("R10 full width", result, {512{1'b1}});

    // R7 legacy, R8 ignored controls
    rand512(ra); rand512(rb); rand512(rd);
    txn("R7 legacy", ra, rb, rd, '0, 0, 0, 0, 0, 2'd3, 1);
    check("R7 value", result, {rd[511:128], ~rd[127:0] & rb[127:0]});
    txn("R8 legacy ignores", ra, rb, rd, 16'h0000, 1, 1, 1, 1, 2'd0, 1);
    check("R8 value", result, {rd[511:128], ~rd[127:0] & rb[127:0]});

    // R9 hold
    held = result;
    src_a = ~src_a; src_b = ~src_b; in_valid = 1'b0;
    @(negedge clk);
    check("R9 hold", result, held);
    check("R9 no valid", {511'd0, out_valid}, '0);

    // R11 reset wins over a valid input
    in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    check("R11 mid reset", {result, out_valid, vlen_err} == '0 ? 512'd0 : 512'd1, 512'd0);

    // Near-exhaustive sweep over mode combinations
    for (int c = 0; c < 128; c++) begin
      for (int mi = 0; mi < 4; mi++) begin
        rand512(ra); rand512(rb); rand512(rd);
        txn("sweep R1 R2 R3 R4 R5 R6 R7 R8", ra, rb, rd, masks[mi],
            c[0], c[1], c[2], c[3], c[5:4], c[6]);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule